// File: doc/BRIEF.md
# Trigger Marker Button Controller

This block turns three raw pushbuttons into two 12-bit marker positions for an oscilloscope-style display: a trigger level (vertical position) and a trigger time (horizontal position). Two buttons adjust a marker each. The third is a modifier: while it is held, it reverses the direction in which each adjust button moves its marker. By default the level button moves its marker down in value and the time button moves its marker up.

Each raw button first passes a two-flop synchroniser. A debounce state machine then changes its clean level only after the input has held a new value for `DEBOUNCE_CYCLES` consecutive clocks. The default is 2^20 clocks. A marker moves by one step of 10 only on the rising edge of a debounced adjust button. The modifier's debounced level is sampled in that same cycle. Results are clamped to the display range and never wrap.

The debounce machine has four states:
- `DB_LOW`: stable released.
- `DB_RISE`: counting a candidate press.
- `DB_HIGH`: stable pressed.
- `DB_FALL`: counting a candidate release.

Its transitions are:
- `DB_LOW`→`DB_RISE` when a high sample arrives.
- `DB_RISE`→`DB_LOW` when a low sample arrives.
- `DB_RISE`→`DB_HIGH` when the run of high samples reaches `DEBOUNCE_CYCLES`.
- `DB_HIGH`→`DB_FALL` when a low sample arrives.
- `DB_FALL`→`DB_HIGH` when a high sample arrives.
- `DB_FALL`→`DB_LOW` when the run of low samples reaches `DEBOUNCE_CYCLES`.

Top module: `trig_marker_ctrl`

## Requirements
- R1: While `rst_n` is low, and on its release, `level_pos` is 360 and `time_pos` is 640. These are the centres of the graticule.
- R2: A press of the level button with the modifier released lowers `level_pos` by 10.
- R3: A press of the level button with the modifier held raises `level_pos` by 10.
- R4: A press of the time button with the modifier released raises `time_pos` by 10.
- R5: A press of the time button with the modifier held lowers `time_pos` by 10.
- R6: A high pulse on an adjust button that is shorter than `DEBOUNCE_CYCLES` synchronised samples does not move either marker.
- R7: Each debounced press moves its marker exactly once. Holding the button does not repeat the step, and releasing it does not move the marker.
- R8: `level_pos` stays within 20..700 and `time_pos` stays within 20..1260. A step that would pass a limit stops at the limit.
- R9: The modifier alone never moves a marker. Its level is taken only at the instant of the press, so changing it while an adjust button is held has no effect.
- R10: The marker changes on the rising clock edge numbered `DEBOUNCE_CYCLES`+3, counting as edge 1 the first edge that samples the raw button high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| btn_level_raw | input | 1 | Raw level-adjust button, high when pressed |
| btn_time_raw | input | 1 | Raw time-adjust button, high when pressed |
| btn_mod_raw | input | 1 | Raw direction-modifier button, high when pressed |
| level_pos | output | 12 | Trigger level marker position |
| time_pos | output | 12 | Trigger time marker position |

## Verification
On every cycle, the assertions check the following:
- Both positions stay inside their ranges.
- A position changes only in the cycle after a press pulse, and then by exactly one step in the selected direction, or to the limit.
- Press pulses last a single cycle.
- A debounced level rises only after a high sample, and the run counter stays below its limit.

Only the bench's scenarios show the rest:
- The exact latency of a press.
- That bounces shorter than the window are rejected.
- That a held or released button does not repeat a step.
- That the modifier acts only at the press instant.
- That the limits are reached after long runs of presses.

// File: rtl/trig_marker_pkg.sv
package trig_marker_pkg;
    typedef enum logic [1:0] {
        DB_LOW  = 2'd0,
        DB_RISE = 2'd1,
        DB_HIGH = 2'd2,
        DB_FALL = 2'd3
    } db_state_t;

    localparam int BTN_LEVEL = 0;
    localparam int BTN_TIME  = 1;
    localparam int BTN_MOD   = 2;
    localparam int NUM_BTN   = 3;
    localparam int NUM_ADJ   = 2;
endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/btn_debounce.sv
module btn_debounce
    import trig_marker_pkg::*;
#(
    parameter int DEB_CYCLES = 1 << 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    output logic level_o
);
    localparam int CW = $clog2(DEB_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(DEB_CYCLES - 1);

    db_state_t state_q, state_n;
    logic [CW-1:0] cnt_q, cnt_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DB_LOW;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    // next state
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        unique case (state_q)
            DB_LOW: if (sync_i) begin
                state_n = DB_RISE;
                cnt_n   = CW'(1);
            end
            DB_RISE: if (!sync_i) begin
                state_n = DB_LOW;
                cnt_n   = '0;
            end else if (cnt_q == LAST) begin
                state_n = DB_HIGH;
                cnt_n   = '0;
            end else begin
                cnt_n = cnt_q + CW'(1);
            end
            DB_HIGH: if (!sync_i) begin
                state_n = DB_FALL;
                cnt_n   = CW'(1);
            end
            DB_FALL: if (sync_i) begin
                state_n = DB_HIGH;
                cnt_n   = '0;
            end else if (cnt_q == LAST) begin
                state_n = DB_LOW;
                cnt_n   = '0;
            end else begin
                cnt_n = cnt_q + CW'(1);
            end
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_o <= 1'b0;
        else        level_o <= (state_n == DB_HIGH) || (state_n == DB_FALL);
    end

    // R6: the clean level rises only after a high synchronised sample
    a_r6_rise_after_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(level_o) |-> $past(sync_i));

    // R6: the run counter never passes the window
    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/marker_pos_reg.sv
module marker_pos_reg #(
    parameter int W      = 12,
    parameter int STEP   = 10,
    parameter int MIN    = 20,
    parameter int MAX    = 700,
    parameter int INIT   = 360,
    parameter bit INVERT = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         press_i,
    input  logic         mod_i,
    output logic [W-1:0] pos_o
);
    localparam logic [W-1:0] STEP_V = W'(STEP);
    localparam logic [W-1:0] MIN_V  = W'(MIN);
    localparam logic [W-1:0] MAX_V  = W'(MAX);
    localparam logic [W-1:0] INIT_V = W'(INIT);
    localparam logic [W-1:0] UP_LIM = W'(MAX - STEP);
    localparam logic [W-1:0] DN_LIM = W'(MIN + STEP);

    logic         up;
    logic [W-1:0] pos_n;

    assign up = mod_i ^ INVERT;

    always_comb begin
        pos_n = pos_o;
        if (press_i) begin
            if (up) pos_n = (pos_o >= UP_LIM) ? MAX_V : pos_o + STEP_V;
            else    pos_n = (pos_o <= DN_LIM) ? MIN_V : pos_o - STEP_V;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_o <= INIT_V;
        else        pos_o <= pos_n;
    end

    // R8: the position stays in range
    a_r8_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_o >= MIN_V) && (pos_o <= MAX_V));

    // R7: the position changes only after a press pulse
    a_r7_change_needs_press: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_o != $past(pos_o)) |-> $past(press_i));

    // R3/R4: an upward step adds one step, or stops at the top limit
    a_r4_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (press_i && up && pos_o < UP_LIM) |=> (pos_o == $past(pos_o) + STEP_V));

    // R2/R5: a downward step subtracts one step, or stops at the bottom limit
    a_r5_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (press_i && !up && pos_o > DN_LIM) |=> (pos_o == $past(pos_o) - STEP_V));
endmodule

// File: rtl/trig_marker_ctrl.sv
module trig_marker_ctrl
    import trig_marker_pkg::*;
#(
    parameter int POS_W           = 12,
    parameter int DEBOUNCE_CYCLES = 1 << 20,
    parameter int SYNC_STAGES     = 2,
    parameter int STEP            = 10,
    parameter int LEVEL_MIN       = 20,
    parameter int LEVEL_MAX       = 700,
    parameter int TIME_MIN        = 20,
    parameter int TIME_MAX        = 1260
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             btn_level_raw,
    input  logic             btn_time_raw,
    input  logic             btn_mod_raw,
    output logic [POS_W-1:0] level_pos,
    output logic [POS_W-1:0] time_pos
);
    localparam int LEVEL_MID = (LEVEL_MIN + LEVEL_MAX) / 2;
    localparam int TIME_MID  = (TIME_MIN + TIME_MAX) / 2;

    logic [NUM_BTN-1:0] raw, synced, clean;
    logic [NUM_ADJ-1:0] clean_q, press;

    assign raw[BTN_LEVEL] = btn_level_raw;
    assign raw[BTN_TIME]  = btn_time_raw;
    assign raw[BTN_MOD]   = btn_mod_raw;

    for (genvar i = 0; i < NUM_BTN; i++) begin : g_btn
        btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .rst_n(rst_n), .async_i(raw[i]), .sync_o(synced[i]));
        btn_debounce #(.DEB_CYCLES(DEBOUNCE_CYCLES)) u_deb (
            .clk(clk), .rst_n(rst_n), .sync_i(synced[i]), .level_o(clean[i]));
    end

    // rising-edge detection of the adjust buttons
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clean_q <= '0;
        else        clean_q <= clean[NUM_ADJ-1:0];
    end
    assign press = clean[NUM_ADJ-1:0] & ~clean_q;

    // level: default down, up with modifier
    marker_pos_reg #(.W(POS_W), .STEP(STEP), .MIN(LEVEL_MIN), .MAX(LEVEL_MAX),
                     .INIT(LEVEL_MID), .INVERT(1'b0)) u_level (
        .clk(clk), .rst_n(rst_n), .press_i(press[BTN_LEVEL]),
        .mod_i(clean[BTN_MOD]), .pos_o(level_pos));

    // time: default up, down with modifier
    marker_pos_reg #(.W(POS_W), .STEP(STEP), .MIN(TIME_MIN), .MAX(TIME_MAX),
                     .INIT(TIME_MID), .INVERT(1'b1)) u_time (
        .clk(clk), .rst_n(rst_n), .press_i(press[BTN_TIME]),
        .mod_i(clean[BTN_MOD]), .pos_o(time_pos));

    // R7: a press pulse lasts a single cycle
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (press != '0) |=> ((press & $past(press)) == '0));

    // R9: the modifier never produces a press on its own
    a_r9_mod_no_press: assert property (@(posedge clk) disable iff (!rst_n)
        (press == '0) |=> (level_pos == $past(level_pos)) && (time_pos == $past(time_pos)));
endmodule

// File: tb/trig_marker_ctrl_test.sv
module trig_marker_ctrl_test;
    localparam int DEB = 4;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic b_lvl = 1'b0, b_tim = 1'b0, b_mod = 1'b0;
    logic [11:0] level_pos, time_pos;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    trig_marker_ctrl #(.DEBOUNCE_CYCLES(DEB)) uut (
        .clk(clk), .rst_n(rst_n), .btn_level_raw(b_lvl), .btn_time_raw(b_tim),
        .btn_mod_raw(b_mod), .level_pos(level_pos), .time_pos(time_pos));

    // behavioural reference model
    int m_lvl, m_tim;
    bit [2:0] s1, s2, db, pend;
    int run [3];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_lvl = 360; m_tim = 640;
            s1 = '0; s2 = '0; db = '0; pend = '0;
            for (int i = 0; i < 3; i++) run[i] = 0;
        end else begin
            if (pend[0]) m_lvl = db[2] ? ((m_lvl + 10 > 700) ? 700 : m_lvl + 10)
                                       : ((m_lvl - 10 < 20) ? 20 : m_lvl - 10);
            if (pend[1]) m_tim = db[2] ? ((m_tim - 10 < 20) ? 20 : m_tim - 10)
                                       : ((m_tim + 10 > 1260) ? 1260 : m_tim + 10);
            pend = '0;
            for (int i = 0; i < 3; i++) begin
                if (s2[i] != db[i]) begin
                    run[i]++;
                    if (run[i] == DEB) begin
                        db[i] = ~db[i];
                        run[i] = 0;
                        if (db[i] && i < 2) pend[i] = 1'b1;
                    end
                end else begin
                    run[i] = 0;
                end
            end
            s2 = s1;
            s1 = {b_mod, b_tim, b_lvl};
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // compare with the model on every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2/R3/R8 level vs model", int'(level_pos), m_lvl);
            check("R4/R5/R8 time vs model", int'(time_pos), m_tim);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic wait_cycles(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic press_level();
        b_lvl = 1'b1; wait_cycles(DEB + 4);
        b_lvl = 1'b0; wait_cycles(DEB + 4);
    endtask

    task automatic press_time();
        b_tim = 1'b1; wait_cycles(DEB + 4);
        b_tim = 1'b0; wait_cycles(DEB + 4);
    endtask

    task automatic set_mod(input logic v);
        b_mod = v; wait_cycles(DEB + 4);
    endtask

    initial begin
        wait_cycles(3);
        check("R1 level in reset", int'(level_pos), 360);
        check("R1 time in reset", int'(time_pos), 640);
        rst_n = 1'b1;
        wait_cycles(2);
        check("R1 level after reset", int'(level_pos), 360);
        check("R1 time after reset", int'(time_pos), 640);

        // R10 latency and R2 default direction
        b_lvl = 1'b1;
        for (int k = 1; k <= DEB + 3; k++) begin
            @(posedge clk); @(negedge clk);
            if (k == DEB + 2) check("R10 no change before latency", int'(level_pos), 360);
            if (k == DEB + 3) check("R10 R2 change at latency", int'(level_pos), 350);
        end
        wait_cycles(40);
        check("R7 held button steps once", int'(level_pos), 350);
        b_lvl = 1'b0; wait_cycles(DEB + 6);
        check("R7 release does not step", int'(level_pos), 350);

        // R3 modifier reverses the level step
        set_mod(1'b1);
        check("R9 modifier alone level", int'(level_pos), 350);
        check("R9 modifier alone time", int'(time_pos), 640);
        press_level();
        check("R3 level up with modifier", int'(level_pos), 360);
        // R5
        press_time();
        check("R5 time down with modifier", int'(time_pos), 630);
        set_mod(1'b0);
        // R4
        press_time();
        check("R4 time up", int'(time_pos), 640);

        // R6 bounce shorter than the window
        for (int j = 0; j < 5; j++) begin
            b_lvl = 1'b1; wait_cycles(DEB - 1);
            b_lvl = 1'b0; wait_cycles(2);
        end
        wait_cycles(DEB + 4);
        check("R6 bounce ignored", int'(level_pos), 360);

        // R9 modifier sampled only at the press instant
        b_lvl = 1'b1; wait_cycles(DEB + 4);
        check("R2 step before modifier change", int'(level_pos), 350);
        b_mod = 1'b1; wait_cycles(DEB + 6);
        check("R9 late modifier has no effect", int'(level_pos), 350);
        b_lvl = 1'b0; wait_cycles(DEB + 4);
        set_mod(1'b0);

        // R8 clamps
        for (int j = 0; j < 40; j++) press_level();
        check("R8 level bottom clamp", int'(level_pos), 20);
        set_mod(1'b1);
        for (int j = 0; j < 72; j++) press_level();
        check("R8 level top clamp", int'(level_pos), 700);
        set_mod(1'b0);
        for (int j = 0; j < 64; j++) press_time();
        check("R8 time top clamp", int'(time_pos), 1260);
        set_mod(1'b1);
        for (int j = 0; j < 126; j++) press_time();
        check("R8 time bottom clamp", int'(time_pos), 20);
        set_mod(1'b0);

        wait_cycles(5);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule